// File: doc/BRIEF.md
# LPC Memory Write Cycle Receiver

This block sits on the device side of a 4-bit multiplexed LPC-style bus and receives host memory-write cycles. On every clock it samples the four shared data lines and the active-low frame strobe. It steps through the start, cycle-type, address and data fields, and then runs the turnaround and sync handshake. When the last data nibble has arrived it hands the assembled address and byte to a downstream program/erase launcher as a one-clock pulse.

The host may cancel a cycle at any clock after its start by pulling the frame strobe low. The receiver then releases the shared lines, drops its field sequencing and waits until the host sends a stop start code before it accepts new cycles. The launch decision is taken only on the final data nibble. An abort that arrives up to and including that nibble therefore cancels the write completely. An abort that arrives after the launch does not withdraw it.

Top module: `lpc_wr_rx`

## Requirements
- R1: A synchronous active-high reset, applied at any point (including during a cycle or after an abort), leaves the block ready for a new cycle with `lad_oe` and `launch_valid` low.
- R2: A frame-strobe-low clock with start code 0000b, followed by a cycle type, eight address nibbles (most significant first) and two data nibbles (low nibble first), gives exactly one `launch_valid` pulse. The pulse is in the clock after the final data nibble (clock 13, counting the start as clock 1) and carries the assembled 32-bit address and 8-bit data.
- R3: Cycle types 0110b and 0111b are both accepted as memory writes. Any other type value ends the cycle with no launch and with `lad_oe` never asserted.
- R4: A start code other than 0000b or 1111b, and also 1111b while ready, is ignored: no launch and no drive. A following valid write completes normally.
- R5: A frame strobe low at any clock from 2 to 12 of a cycle aborts it, and no launch pulse is produced.
- R6: After an abort, `lad_oe` stays low and start code 0000b is ignored. Only a frame-strobe-low clock carrying start code 1111b makes the block ready again, after which a valid write launches.
- R7: An abort at clock 13 or 14 does not withdraw the launch pulse already issued for that cycle.
- R8: In a completed cycle, `lad_oe` is high only during clocks 15 and 16. At clock 15 `lad_out` is 0000b (sync ready) and at clock 16 it is 1111b.
- R9: A frame strobe low sampled while the device drives the lines makes `lad_oe` low in the next clock.
- R10: `launch_valid` never stays high for two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| lad_in | input | 4 | Sampled value of the shared data lines |
| lframe_n | input | 1 | Frame strobe, active low |
| lad_out | output | 4 | Value the device places on the data lines when enabled |
| lad_oe | output | 1 | Output enable for the data-line drivers (low means high impedance) |
| launch_valid | output | 1 | One-clock program request pulse |
| launch_addr | output | 32 | Address of the completed write |
| launch_data | output | 8 | Data byte of the completed write |

## Verification
The properties assume the host pulls the frame strobe low only for a start clock or to abort. They also assume the host never begins a new start before the previous cycle's closing turnaround has ended, and that the turnaround length parameter is at least two. The stimulus keeps to this: every cycle runs its full seventeen clocks with the strobe high except at the start and at a single chosen abort clock. The abort clock is swept across every position from 2 to 17. Recovery is always a separate stop-code clock followed by an idle clock.

// File: rtl/lpc_wr_pkg.sv
package lpc_wr_pkg;

    localparam logic [3:0] START_MEM  = 4'b0000;
    localparam logic [3:0] START_STOP = 4'b1111;
    localparam logic [3:0] SYNC_READY = 4'b0000;
    localparam logic [3:0] TAR_IDLE   = 4'b1111;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTYPE,
        ST_ADDR,
        ST_DATA,
        ST_TAR_IN,
        ST_SYNC,
        ST_TAR_OUT,
        ST_TAR_END,
        ST_ABORT
    } rx_state_e;

    typedef struct packed {
        logic addr_we;
        logic data_we;
        logic data_last;
    } nib_ctl_t;

    function automatic logic is_mem_write(input logic [3:0] nib);
        return nib[3:1] == 3'b011;
    endfunction

    function automatic logic in_cycle(input rx_state_e s);
        return !(s == ST_IDLE || s == ST_ABORT);
    endfunction

    function automatic logic drives_bus(input rx_state_e s);
        return (s == ST_SYNC) || (s == ST_TAR_OUT);
    endfunction

endpackage

// File: rtl/lpc_field_fsm.sv
module lpc_field_fsm
    import lpc_wr_pkg::*;
#(
    parameter int ADDR_NIBBLES = 8,
    parameter int DATA_NIBBLES = 2,
    parameter int TAR_CLKS     = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic [3:0] lad_in,
    input  logic      lframe_n,
    output rx_state_e state,
    output nib_ctl_t  ctl
);

    localparam int SPAN  = ADDR_NIBBLES + DATA_NIBBLES + TAR_CLKS;
    localparam int CNT_W = (SPAN > 2) ? $clog2(SPAN) : 1;

    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBBLES - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_NIBBLES - 1);
    localparam logic [CNT_W-1:0] TIN_LAST  = CNT_W'(TAR_CLKS - 1);
    localparam logic [CNT_W-1:0] TEND_LAST = CNT_W'((TAR_CLKS > 1) ? TAR_CLKS - 2 : 0);

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (in_cycle(state_q) && !lframe_n) begin
            state_d = ST_ABORT;
            cnt_d   = '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (!lframe_n && lad_in == START_MEM) begin
                        state_d = ST_CTYPE;
                    end
                end
                ST_ABORT: begin
                    if (!lframe_n && lad_in == START_STOP) begin
                        state_d = ST_IDLE;
                    end
                end
                ST_CTYPE: begin
                    cnt_d   = '0;
                    state_d = is_mem_write(lad_in) ? ST_ADDR : ST_IDLE;
                end
                ST_ADDR: begin
                    if (cnt_q == ADDR_LAST) begin
                        state_d = ST_DATA;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (cnt_q == DATA_LAST) begin
                        state_d = ST_TAR_IN;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_TAR_IN: begin
                    if (cnt_q == TIN_LAST) begin
                        state_d = ST_SYNC;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_SYNC: begin
                    state_d = ST_TAR_OUT;
                end
                ST_TAR_OUT: begin
                    cnt_d   = '0;
                    state_d = (TAR_CLKS > 1) ? ST_TAR_END : ST_IDLE;
                end
                ST_TAR_END: begin
                    if (cnt_q == TEND_LAST) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        ctl.addr_we   = (state_q == ST_ADDR) && lframe_n;
        ctl.data_we   = (state_q == ST_DATA) && lframe_n;
        ctl.data_last = ctl.data_we && (cnt_q == DATA_LAST);
    end

    assign state = state_q;

endmodule

// File: rtl/lpc_nibble_capture.sv
module lpc_nibble_capture
    import lpc_wr_pkg::*;
#(
    parameter int ADDR_NIBBLES = 8,
    parameter int DATA_NIBBLES = 2,
    localparam int ADDR_W = 4 * ADDR_NIBBLES,
    localparam int DATA_W = 4 * DATA_NIBBLES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        lad_in,
    input  nib_ctl_t          ctl,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_next
);

    logic [DATA_W-1:0] data_q;

    // Address arrives most significant nibble first: shift in at the bottom.
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (ctl.addr_we) begin
            addr_q <= {addr_q[ADDR_W-5:0], lad_in};
        end
    end

    // Data arrives least significant nibble first: shift in at the top.
    generate
        if (DATA_NIBBLES == 1) begin : g_single
            assign data_next = lad_in;
        end else begin : g_multi
            assign data_next = {lad_in, data_q[DATA_W-1:4]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (ctl.data_we) begin
            data_q <= data_next;
        end
    end

endmodule

// File: rtl/lpc_launch_gate.sv
module lpc_launch_gate
    import lpc_wr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  nib_ctl_t          ctl,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              launch_valid,
    output logic [ADDR_W-1:0] launch_addr,
    output logic [DATA_W-1:0] launch_data
);

    // The request is committed only when the final data nibble is taken
    // with the frame strobe high; earlier aborts never reach this point.
    always_ff @(posedge clk) begin
        if (rst) begin
            launch_valid <= 1'b0;
            launch_addr  <= '0;
            launch_data  <= '0;
        end else begin
            launch_valid <= ctl.data_last;
            if (ctl.data_last) begin
                launch_addr <= addr_in;
                launch_data <= data_in;
            end
        end
    end

endmodule

// File: rtl/lpc_lad_drive.sv
module lpc_lad_drive
    import lpc_wr_pkg::*;
(
    input  rx_state_e  state,
    output logic       lad_oe,
    output logic [3:0] lad_out
);

    always_comb begin
        lad_oe  = drives_bus(state);
        lad_out = (state == ST_SYNC) ? SYNC_READY : TAR_IDLE;
    end

endmodule

// File: rtl/lpc_wr_rx.sv
module lpc_wr_rx
    import lpc_wr_pkg::*;
#(
    parameter int ADDR_NIBBLES = 8,
    parameter int DATA_NIBBLES = 2,
    parameter int TAR_CLKS     = 2,
    localparam int ADDR_W = 4 * ADDR_NIBBLES,
    localparam int DATA_W = 4 * DATA_NIBBLES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        lad_in,
    input  logic              lframe_n,
    output logic [3:0]        lad_out,
    output logic              lad_oe,
    output logic              launch_valid,
    output logic [ADDR_W-1:0] launch_addr,
    output logic [DATA_W-1:0] launch_data
);

    rx_state_e         state;
    nib_ctl_t          ctl;
    logic [ADDR_W-1:0] addr_acc;
    logic [DATA_W-1:0] data_acc;

    lpc_field_fsm #(
        .ADDR_NIBBLES(ADDR_NIBBLES),
        .DATA_NIBBLES(DATA_NIBBLES),
        .TAR_CLKS    (TAR_CLKS)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .lad_in  (lad_in),
        .lframe_n(lframe_n),
        .state   (state),
        .ctl     (ctl)
    );

    lpc_nibble_capture #(
        .ADDR_NIBBLES(ADDR_NIBBLES),
        .DATA_NIBBLES(DATA_NIBBLES)
    ) u_cap (
        .clk      (clk),
        .rst      (rst),
        .lad_in   (lad_in),
        .ctl      (ctl),
        .addr_q   (addr_acc),
        .data_next(data_acc)
    );

    lpc_launch_gate #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_gate (
        .clk         (clk),
        .rst         (rst),
        .ctl         (ctl),
        .addr_in     (addr_acc),
        .data_in     (data_acc),
        .launch_valid(launch_valid),
        .launch_addr (launch_addr),
        .launch_data (launch_data)
    );

    lpc_lad_drive u_drv (
        .state  (state),
        .lad_oe (lad_oe),
        .lad_out(lad_out)
    );

endmodule

// File: rtl/lpc_wr_rx_chk.sv
module lpc_wr_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       lframe_n,
    input logic [3:0] lad_out,
    input logic       lad_oe,
    input logic       launch_valid
);

    // R1: the clock after reset shows an idle block
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!lad_oe && !launch_valid));

    // R5: a launch is only ever taken from a clock with the strobe high
    assert_launch_frame_high_R5: assert property (@(posedge clk) disable iff (rst)
        launch_valid |-> $past(lframe_n));

    // R7: the launch clock falls in the inbound turnaround, not while driving
    assert_launch_not_driving_R7: assert property (@(posedge clk) disable iff (rst)
        launch_valid |-> !lad_oe);

    // R8: device driving always opens with the sync code
    assert_sync_opens_drive_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(lad_oe) |-> (lad_out == 4'b0000));

    // R8: only sync or idle-turnaround values are ever driven
    assert_drive_values_R8: assert property (@(posedge clk) disable iff (rst)
        lad_oe |-> (lad_out == 4'b0000 || lad_out == 4'b1111));

    // R9: a low strobe releases the lines in the next clock
    assert_abort_releases_R9: assert property (@(posedge clk) disable iff (rst)
        !lframe_n |=> !lad_oe);

    // R10: launch is a single-clock pulse
    assert_launch_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        launch_valid |=> !launch_valid);

endmodule

bind lpc_wr_rx lpc_wr_rx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .lframe_n    (lframe_n),
    .lad_out     (lad_out),
    .lad_oe      (lad_oe),
    .launch_valid(launch_valid)
);

// File: tb/test_lpc_wr_rx.sv
`timescale 1ns/1ps
module test_lpc_wr_rx;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  lad_in;
    logic        lframe_n;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic        launch_valid;
    logic [31:0] launch_addr;
    logic [7:0]  launch_data;

    int n_chk = 0;
    int n_bad = 0;
    bit ready = 1'b1;

    logic        oe_at  [0:19];
    logic [3:0]  out_at [0:19];
    logic        lv_at  [0:19];
    logic [31:0] la_at  [0:19];
    logic [7:0]  ld_at  [0:19];

    always #2 clk = ~clk;

    lpc_wr_rx i_lpc_wr_rx (
        .clk         (clk),
        .rst         (rst),
        .lad_in      (lad_in),
        .lframe_n    (lframe_n),
        .lad_out     (lad_out),
        .lad_oe      (lad_oe),
        .launch_valid(launch_valid),
        .launch_addr (launch_addr),
        .launch_data (launch_data)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Record the outputs seen during clock idx, then drive that clock's inputs.
    task automatic step(input logic [3:0] nib, input logic fr, input int idx);
        @(negedge clk);
        oe_at[idx]  = lad_oe;
        out_at[idx] = lad_out;
        lv_at[idx]  = launch_valid;
        la_at[idx]  = launch_addr;
        ld_at[idx]  = launch_data;
        lad_in   = nib;
        lframe_n = fr;
    endtask

    task automatic recover();
        step(4'hF, 1'b0, 0);
        step(4'hF, 1'b1, 0);
        ready = 1'b1;
    endtask

    // One 17-clock write cycle; ab is the clock at which the strobe is pulled
    // low to abort (0 for none).
    task automatic run_cycle(input logic [3:0] start, input logic [3:0] ctype,
                             input logic [31:0] addr, input logic [7:0] data,
                             input int ab, input string tag);
        bit ct_ok, go, launch_exp, aborted;
        int nlv;
        logic [18:0] oe_act, oe_exp;
        for (int k = 1; k <= 17; k++) begin
            logic [3:0] nib;
            logic       fr;
            fr = 1'b1;
            if (k == 1)       begin nib = start; fr = 1'b0; end
            else if (k == 2)  nib = ctype;
            else if (k <= 10) nib = addr[31 - 4*(k-3) -: 4];
            else if (k == 11) nib = data[3:0];
            else if (k == 12) nib = data[7:4];
            else              nib = 4'hF;
            if (k == ab) begin nib = 4'h5; fr = 1'b0; end
            step(nib, fr, k);
        end
        step(4'hF, 1'b1, 18);

        ct_ok      = (ctype[3:1] == 3'b011);
        go         = ready && (start == 4'h0);
        launch_exp = go && ct_ok && (ab == 0 || ab >= 13);
        aborted    = go && (ab != 0) && (ab == 2 || ct_ok);

        nlv = 0;
        oe_act = '0;
        oe_exp = '0;
        for (int k = 2; k <= 18; k++) begin
            if (lv_at[k]) nlv++;
            oe_act[k] = oe_at[k];
            oe_exp[k] = launch_exp && (k == 15 || k == 16) && (ab == 0 || ab >= k);
        end
        check(nlv == (launch_exp ? 1 : 0), {tag, " launch count"}, nlv, launch_exp ? 1 : 0);
        if (launch_exp) begin
            check(lv_at[13] === 1'b1, {tag, " R2 launch clock"}, lv_at[13], 1);
            check(la_at[13] === addr, {tag, " R2 address"}, la_at[13], addr);
            check(ld_at[13] === data, {tag, " R2 data"}, ld_at[13], data);
        end
        check(oe_act === oe_exp, {tag, " R8 drive window"}, oe_act, oe_exp);
        if (oe_exp[15])
            check(out_at[15] === 4'h0, {tag, " R8 sync code"}, out_at[15], 0);
        if (oe_exp[16])
            check(out_at[16] === 4'hF, {tag, " R8 turnaround code"}, out_at[16], 4'hF);

        if (!ready) ready = (start == 4'hF);
        else if (aborted) ready = 1'b0;
    endtask

    function automatic logic [31:0] mk_addr(input int i);
        return 32'h1234_5678 ^ (32'(i) * 32'h9E37_79B9);
    endfunction

    function automatic logic [7:0] mk_data(input int i);
        return 8'(i * 37 + 5);
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        lad_in = 4'hF;
        lframe_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(lad_oe === 1'b0, "R1 oe after reset", lad_oe, 0);
        check(launch_valid === 1'b0, "R1 launch after reset", launch_valid, 0);

        // R2: plain writes over varied address and data patterns
        for (int i = 0; i < 8; i++)
            run_cycle(4'h0, 4'h6 | 4'(i & 1), mk_addr(i), mk_data(i), 0, "R2");
        run_cycle(4'h0, 4'h6, 32'hFFFF_FFFF, 8'hFF, 0, "R2");
        run_cycle(4'h0, 4'h7, 32'h0000_0000, 8'h00, 0, "R2");

        // R3: every cycle-type value
        for (int t = 0; t < 16; t++)
            run_cycle(4'h0, 4'(t), mk_addr(t + 20), mk_data(t + 20), 0, "R3");

        // R4: every non-memory start code, each followed by a good write
        for (int s = 1; s < 16; s++) begin
            run_cycle(4'(s), 4'h6, mk_addr(s + 40), mk_data(s + 40), 0, "R4");
            run_cycle(4'h0, 4'h6, mk_addr(s + 60), mk_data(s + 60), 0, "R4");
        end

        // R5 / R7 / R9: abort at every clock from 2 to 17
        for (int a = 2; a <= 17; a++) begin
            string tg;
            tg = (a <= 12) ? "R5" : ((a <= 14) ? "R7" : "R9");
            run_cycle(4'h0, 4'h6, mk_addr(a + 80), mk_data(a + 80), a, tg);
            if (!ready) recover();
            run_cycle(4'h0, 4'h7, mk_addr(a + 100), mk_data(a + 100), 0, tg);
        end

        // R6: no response after abort until the stop start code
        run_cycle(4'h0, 4'h6, mk_addr(200), mk_data(200), 7, "R6");
        run_cycle(4'h0, 4'h6, mk_addr(201), mk_data(201), 0, "R6");
        run_cycle(4'h3, 4'h6, mk_addr(202), mk_data(202), 0, "R6");
        check(ready == 1'b0, "R6 still blocked", ready, 0);
        run_cycle(4'hF, 4'h6, mk_addr(203), mk_data(203), 0, "R6");
        run_cycle(4'h0, 4'h6, mk_addr(204), mk_data(204), 0, "R6");

        // R1: reset in the middle of a cycle, then reset out of the aborted state
        for (int k = 1; k <= 6; k++)
            step((k == 1) ? 4'h0 : 4'h6, (k == 1) ? 1'b0 : 1'b1, 0);
        rst = 1'b1;
        step(4'hF, 1'b1, 0);
        step(4'hF, 1'b1, 0);
        rst = 1'b0;
        step(4'hF, 1'b1, 0);
        check(lad_oe === 1'b0 && launch_valid === 1'b0, "R1 mid-cycle reset",
              {lad_oe, launch_valid}, 0);
        run_cycle(4'h0, 4'h6, mk_addr(300), mk_data(300), 0, "R1");
        run_cycle(4'h0, 4'h6, mk_addr(301), mk_data(301), 4, "R1");
        rst = 1'b1;
        step(4'hF, 1'b1, 0);
        rst = 1'b0;
        ready = 1'b1;
        step(4'hF, 1'b1, 0);
        run_cycle(4'h0, 4'h7, mk_addr(302), mk_data(302), 0, "R1");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule